// File: doc/BRIEF.md
# Packed-decimal correction and digit split unit

This unit performs two fixed corrections on an 8-bit accumulator byte that sit beside the main ALU of a small processor core. The first repairs the byte after a binary subtraction of two packed decimal values, so that both nibbles are valid decimal digits again, and produces the new carry and half-carry flags. The second splits a binary byte of up to 255 into two unpacked decimal digits, the tens going to the high result byte and the units to the low result byte, as used after multiplying two single digits.

A one-bit operation select chooses the correction. The unit samples its inputs on a rising clock edge where the enable is high and presents the registered result on its outputs from the next cycle. When the enable is low every output keeps its value. Operand fetch, register writeback and instruction decode belong to the surrounding core.

Top module: `bcd_adjust_unit`

## Requirements
- R1: In the cycle after a synchronous active-low reset, every output (both result bytes and all five flags) reads zero.
- R2: Subtract correction (op_i = 0): the low step fires when acc_i[3:0] exceeds 9 or af_i is 1; af_o is then 1, otherwise 0.
- R3: Subtract correction: cf_o is 1 exactly when the original acc_i exceeds 0x99 or cf_i is 1; a borrow out of the low step never reaches cf_o.
- R4: Subtract correction: acc_lo_o equals acc_i minus 0x06 if the low step fired, minus a further 0x60 if the high step of R3 fired, modulo 256.
- R5: After a subtract correction, pf_o is 1 when acc_lo_o holds an even number of one bits, zf_o is 1 when acc_lo_o is zero, and sf_o equals acc_lo_o bit 7.
- R6: Digit split (op_i = 1): acc_hi_o receives acc_i divided by 10 and acc_lo_o receives acc_i modulo 10, both unsigned.
- R7: After a digit split, cf_o is 0, af_o keeps its previous value, pf_o is the even parity of acc_lo_o, zf_o is 1 when the 16-bit pair {acc_hi_o, acc_lo_o} is zero, and sf_o equals acc_hi_o bit 7.
- R8: When en_i is 0 no output changes; a subtract correction leaves acc_hi_o unchanged.
- R9: A result appears on the outputs one clock edge after the edge that samples en_i high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Perform the selected correction at this edge |
| op_i | input | 1 | 0 = subtract correction, 1 = digit split |
| acc_i | input | 8 | Accumulator byte to correct |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming half-carry flag |
| acc_lo_o | output | 8 | Corrected low result byte |
| acc_hi_o | output | 8 | High result byte (tens digit of a split) |
| cf_o | output | 1 | Carry flag result |
| af_o | output | 1 | Half-carry flag result |
| pf_o | output | 1 | Even-parity flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |

## Verification
The hardest case to reach is a low step that borrows while the high step stays idle, because only there does the discarded borrow matter: it needs a small byte (below 0x06) together with a set half-carry and a clear carry. The stimulus sweeps every byte against all four carry and half-carry combinations in subtract mode, so bytes such as 0x00 to 0x05 with only the half-carry set are covered, and directed cases add 0x05 and 0x9A on their own. Every byte is also split in digit mode, including the maximum 255 and zero, and seeded random traffic interleaves both modes with idle cycles to show that outputs hold.

// File: rtl/bcd_adj_pkg.sv
// Package: shared operation encoding for the decimal correction unit.
// Assumes: a single select bit distinguishes the two corrections.
package bcd_adj_pkg;

    // Operation select values seen on op_i.
    typedef enum logic {
        ADJ_SUB   = 1'b0,
        ADJ_SPLIT = 1'b1
    } adj_op_e;

endpackage

// File: rtl/bcd_sub_adjust.sv
// Module: bcd_sub_adjust
// Repairs a byte holding two packed decimal digits after a binary
// subtraction. Purely combinational.
// Assumes: RADIX is below 2**DIGIT_W; the byte is two digits wide.
// The low step would produce a borrow into the carry, but the high step
// decides the carry from the original byte and original carry alone, so
// that intermediate borrow is not carried out of this module.
module bcd_sub_adjust #(
    parameter int DIGIT_W = 4,
    parameter int RADIX   = 10
) (
    input  logic [2*DIGIT_W-1:0] acc,
    input  logic                 cf_in,
    input  logic                 af_in,
    output logic [2*DIGIT_W-1:0] acc_out,
    output logic                 cf_out,
    output logic                 af_out
);
    localparam int DATA_W = 2 * DIGIT_W;
    localparam int FIX    = (2 ** DIGIT_W) - RADIX;
    localparam logic [DIGIT_W-1:0] LO_LIMIT = DIGIT_W'(RADIX - 1);
    localparam logic [DATA_W-1:0]  HI_LIMIT = DATA_W'(((RADIX - 1) << DIGIT_W) | (RADIX - 1));
    localparam logic [DATA_W-1:0]  LO_FIX   = DATA_W'(FIX);
    localparam logic [DATA_W-1:0]  HI_FIX   = DATA_W'(FIX << DIGIT_W);

    logic                lo_fire;
    logic                hi_fire;
    logic [DATA_W-1:0]   mid;

    // Low-digit step, then high-digit step tested on the original byte.
    always_comb begin
        lo_fire = (acc[DIGIT_W-1:0] > LO_LIMIT) || af_in;
        mid     = lo_fire ? (acc - LO_FIX) : acc;
        hi_fire = (acc > HI_LIMIT) || cf_in;
        acc_out = hi_fire ? (mid - HI_FIX) : mid;
        cf_out  = hi_fire;
        af_out  = lo_fire;
    end
endmodule

// File: rtl/bcd_div_const.sv
// Module: bcd_div_const
// Unsigned division of a DATA_W-bit value by a fixed constant, built as
// an unrolled restoring divider with one compare-subtract stage per bit.
// Assumes: 0 < DIVISOR < 2**DATA_W, so a partial remainder fits DATA_W bits.
module bcd_div_const #(
    parameter int DATA_W  = 8,
    parameter int DIVISOR = 10
) (
    input  logic [DATA_W-1:0] num,
    output logic [DATA_W-1:0] quo,
    output logic [DATA_W-1:0] rem
);
    localparam int TW = DATA_W + 1;
    localparam logic [TW-1:0] DIV_T = TW'(DIVISOR);

    logic [DATA_W-1:0] part [DATA_W+1];

    assign part[0] = '0;

    // One stage per dividend bit, most significant bit first.
    for (genvar g = 0; g < DATA_W; g++) begin : g_stage
        logic [TW-1:0] trial;
        logic [TW-1:0] diff;
        assign trial = {part[g], num[DATA_W-1-g]};
        assign diff  = trial - DIV_T;
        assign quo[DATA_W-1-g] = (trial >= DIV_T);
        assign part[g+1] = (trial >= DIV_T) ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
    end

    assign rem = part[DATA_W];

    // Divider result must reconstruct the dividend with a remainder below the divisor.
    always_comb begin
        if (!$isunknown(num)) begin
            p_div_exact_r6: assert (((2*DATA_W)'(quo) * (2*DATA_W)'(DIVISOR) + (2*DATA_W)'(rem)
                                     == (2*DATA_W)'(num)) && (rem < DATA_W'(DIVISOR)))
                else $error("R6 divider mismatch num=%0d quo=%0d rem=%0d", num, quo, rem);
        end
    end
endmodule

// File: rtl/bcd_flag_gen.sv
// Module: bcd_flag_gen
// Produces parity, zero and sign flags from a result byte, optionally
// widened with a high byte for the 16-bit digit-split result.
// Assumes: parity always looks at the low byte only.
module bcd_flag_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic              wide,
    output logic              pf,
    output logic              zf,
    output logic              sf
);
    // Flag derivation for byte or double-byte results.
    always_comb begin
        pf = ~^lo;
        zf = wide ? ((lo == '0) && (hi == '0)) : (lo == '0);
        sf = wide ? hi[DATA_W-1] : lo[DATA_W-1];
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
// Module: bcd_adjust_unit (top)
// Registered decimal correction unit: subtract correction or digit split
// of one accumulator byte, selected per operation.
// Assumes: the core samples outputs one cycle after asserting en_i and
// writes them back itself; outputs not touched by an operation hold.
module bcd_adjust_unit #(
    parameter int DIGIT_W = 4,
    parameter int RADIX   = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  op_i,
    input  logic [2*DIGIT_W-1:0]  acc_i,
    input  logic                  cf_i,
    input  logic                  af_i,
    output logic [2*DIGIT_W-1:0]  acc_lo_o,
    output logic [2*DIGIT_W-1:0]  acc_hi_o,
    output logic                  cf_o,
    output logic                  af_o,
    output logic                  pf_o,
    output logic                  zf_o,
    output logic                  sf_o
);
    import bcd_adj_pkg::*;

    localparam int DATA_W = 2 * DIGIT_W;
    localparam logic [DATA_W-1:0] HI_LIMIT = DATA_W'(((RADIX - 1) << DIGIT_W) | (RADIX - 1));

    adj_op_e            op;
    logic [DATA_W-1:0]  sub_acc;
    logic               sub_cf;
    logic               sub_af;
    logic [DATA_W-1:0]  div_q;
    logic [DATA_W-1:0]  div_r;
    logic [DATA_W-1:0]  nxt_lo;
    logic [DATA_W-1:0]  nxt_hi;
    logic               nxt_pf;
    logic               nxt_zf;
    logic               nxt_sf;
    logic               split_sel;

    assign op        = adj_op_e'(op_i);
    assign split_sel = (op == ADJ_SPLIT);

    bcd_sub_adjust #(.DIGIT_W(DIGIT_W), .RADIX(RADIX)) u_sub (
        .acc     (acc_i),
        .cf_in   (cf_i),
        .af_in   (af_i),
        .acc_out (sub_acc),
        .cf_out  (sub_cf),
        .af_out  (sub_af)
    );

    bcd_div_const #(.DATA_W(DATA_W), .DIVISOR(RADIX)) u_div (
        .num (acc_i),
        .quo (div_q),
        .rem (div_r)
    );

    // Select the candidate result bytes for the chosen operation.
    always_comb begin
        nxt_lo = split_sel ? div_r : sub_acc;
        nxt_hi = split_sel ? div_q : acc_hi_o;
    end

    bcd_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .lo   (nxt_lo),
        .hi   (nxt_hi),
        .wide (split_sel),
        .pf   (nxt_pf),
        .zf   (nxt_zf),
        .sf   (nxt_sf)
    );

    // Result and flag registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_lo_o <= '0;
            acc_hi_o <= '0;
            cf_o     <= 1'b0;
            af_o     <= 1'b0;
            pf_o     <= 1'b0;
            zf_o     <= 1'b0;
            sf_o     <= 1'b0;
        end else if (en_i) begin
            acc_lo_o <= nxt_lo;
            acc_hi_o <= nxt_hi;
            cf_o     <= split_sel ? 1'b0 : sub_cf;
            af_o     <= split_sel ? af_o : sub_af;
            pf_o     <= nxt_pf;
            zf_o     <= nxt_zf;
            sf_o     <= nxt_sf;
        end
    end

    // Idle cycles leave every output untouched.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(acc_lo_o) && $stable(acc_hi_o) && $stable(cf_o) && $stable(af_o)
                   && $stable(pf_o) && $stable(zf_o) && $stable(sf_o)))
        else $error("R8 outputs moved while idle");

    // A subtract correction never touches the high byte.
    p_sub_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !op_i) |=> $stable(acc_hi_o))
        else $error("R8 high byte changed by subtract correction");

    // Carry after subtract correction depends only on the original byte and carry.
    p_sub_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !op_i) |=> (cf_o == (($past(acc_i) > HI_LIMIT) || $past(cf_i))))
        else $error("R3 carry mismatch");

    // Zero flag after subtract correction follows the result byte.
    p_sub_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !op_i) |=> (zf_o == (acc_lo_o == '0)))
        else $error("R5 zero flag mismatch");

    // Split leaves two in-range digits and a clear carry.
    p_split_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i) |=> ((acc_lo_o < DATA_W'(RADIX)) && !cf_o))
        else $error("R6 split digit out of range");

    // Split keeps the half-carry flag.
    p_split_af_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i) |=> $stable(af_o))
        else $error("R7 half-carry changed by split");
endmodule

// File: tb/bcd_adjust_unit_bench.sv
// Bench for bcd_adjust_unit: exhaustive sweeps, directed corners and
// seeded random traffic, checked against bench reference functions.
module bcd_adjust_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en_i;
    logic       op_i;
    logic [7:0] acc_i;
    logic       cf_i;
    logic       af_i;
    logic [7:0] acc_lo_o;
    logic [7:0] acc_hi_o;
    logic       cf_o, af_o, pf_o, zf_o, sf_o;

    int checks = 0;
    int fails  = 0;

    // Reference state of the outputs.
    logic [7:0] m_lo = 0, m_hi = 0;
    logic       m_cf = 0, m_af = 0, m_pf = 0, m_zf = 0, m_sf = 0;

    always #4 clk = ~clk;

    bcd_adjust_unit u_bcd_adjust_unit (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .acc_i(acc_i),
        .cf_i(cf_i), .af_i(af_i), .acc_lo_o(acc_lo_o), .acc_hi_o(acc_hi_o),
        .cf_o(cf_o), .af_o(af_o), .pf_o(pf_o), .zf_o(zf_o), .sf_o(sf_o)
    );

    function automatic logic even_par(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return (n % 2) == 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Update the reference model for one operation.
    task automatic model(input logic op, input logic [7:0] a, input logic c, input logic h);
        if (!op) begin
            logic lo, hi;
            logic [7:0] r;
            lo = (a[3:0] > 4'd9) || h;
            hi = (a > 8'h99) || c;
            r = a;
            if (lo) r = r - 8'h06;
            if (hi) r = r - 8'h60;
            m_lo = r; m_cf = hi; m_af = lo;
            m_pf = even_par(r); m_zf = (r == 0); m_sf = r[7];
        end else begin
            m_hi = a / 8'd10; m_lo = a % 8'd10; m_cf = 0;
            m_pf = even_par(m_lo); m_zf = (a == 0); m_sf = m_hi[7];
        end
    endtask

    task automatic compare_all(input logic op);
        if (!op) begin
            check("R4 subtract result byte", acc_lo_o, m_lo);
            check("R2 half-carry", af_o, m_af);
            check("R3 carry", cf_o, m_cf);
            check("R5 parity/zero/sign", {pf_o, zf_o, sf_o}, {m_pf, m_zf, m_sf});
            check("R8 high byte held", acc_hi_o, m_hi);
        end else begin
            check("R6 split digits", {acc_hi_o, acc_lo_o}, {m_hi, m_lo});
            check("R7 split flags", {cf_o, af_o, pf_o, zf_o, sf_o}, {m_cf, m_af, m_pf, m_zf, m_sf});
        end
    endtask

    // Drive one operation, then check outputs after the capturing edge.
    task automatic run_op(input logic op, input logic [7:0] a, input logic c, input logic h);
        @(negedge clk);
        en_i = 1; op_i = op; acc_i = a; cf_i = c; af_i = h;
        @(negedge clk);
        en_i = 0;
        model(op, a, c, h);
        compare_all(op);
    endtask

    // Idle cycle with scrambled inputs; nothing may move.
    task automatic idle_cycle();
        @(negedge clk);
        en_i = 0; op_i = 1'($urandom); acc_i = 8'($urandom);
        cf_i = 1'($urandom); af_i = 1'($urandom);
        @(negedge clk);
        check("R8 idle hold", {acc_hi_o, acc_lo_o, cf_o, af_o, pf_o, zf_o, sf_o},
              {m_hi, m_lo, m_cf, m_af, m_pf, m_zf, m_sf});
    endtask

    initial begin
        void'($urandom(32'd7319));
        rst_n = 0; en_i = 0; op_i = 0; acc_i = 0; cf_i = 0; af_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset state", {acc_hi_o, acc_lo_o, cf_o, af_o, pf_o, zf_o, sf_o}, 0);

        // R9: result not visible before the sampling edge, visible after it.
        en_i = 1; op_i = 1; acc_i = 8'd97; cf_i = 0; af_i = 0;
        #1 check("R9 no change before edge", {acc_hi_o, acc_lo_o}, 0);
        @(negedge clk);
        en_i = 0;
        model(1, 8'd97, 0, 0);
        check("R9 result after one edge", {acc_hi_o, acc_lo_o}, {8'd9, 8'd7});

        // Directed corners: dropped borrow, both steps, max split, zero split.
        run_op(0, 8'h05, 0, 1);
        check("R3 borrow discarded", {cf_o, acc_lo_o}, {1'b0, 8'hFF});
        run_op(0, 8'h9A, 0, 0);
        check("R4 both steps", acc_lo_o, 8'h34);
        run_op(0, 8'h00, 1, 0);
        run_op(1, 8'd255, 0, 0);
        check("R6 maximum split", {acc_hi_o, acc_lo_o}, {8'd25, 8'd5});
        run_op(1, 8'd0, 0, 0);
        check("R7 zero split flag", zf_o, 1);
        idle_cycle();

        // Exhaustive subtract correction over every byte and flag pair.
        for (int a = 0; a < 256; a++)
            for (int f = 0; f < 4; f++)
                run_op(0, 8'(a), f[1], f[0]);

        // Exhaustive digit split.
        for (int a = 0; a < 256; a++) run_op(1, 8'(a), 1'($urandom), 1'($urandom));

        // Seeded random mix with idle cycles.
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 5) == 0) idle_cycle();
            else run_op(1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule